// File: doc/BRIEF.md
# Processor Memory Cycle Controller

This block answers a 32-bit processor bus on behalf of an internal synchronous RAM. Each cycle it reads the processor's active-low request flag and sequential flag and classifies the cycle as non-sequential, sequential, internal or coprocessor. Only the first two touch memory. A stretch output holds the processor's clock while the controller needs more time. The processor must keep its request stable while that output is high.

The controller keeps the address of the last completed access. A sequential cycle at that address, or at the next halfword or word, completes in the cycle it is presented. Any other access costs one setup cycle. Transfers can be byte, halfword or word sized, with little-endian byte lanes. Read data is spread across the whole bus. A misaligned access is rejected with an abort and changes no memory. A locked read-modify-write (a swap) can finish its write phase without a setup cycle.

Top module: `mem_cycle_ctrl`

## Requirements
- R1: With `mreq_ni`=1 (internal cycle when `seq_i`=0, coprocessor cycle when `seq_i`=1), `wait_o`, `abort_o`, `lane_o` and `rdata_o` are all 0, and memory is not written whatever `write_i` and `wdata_i` carry.
- R2: A memory cycle that is not fast drives `wait_o`=1 in its first cycle and writes nothing then. If the request is held, the next cycle completes with `wait_o`=0.
- R3: A cycle with `mreq_ni`=0, `seq_i`=1 whose address equals the last completed address, or that address plus 2 or plus 4, completes with `wait_o`=0.
- R4: A sequential cycle is slow when no access has completed since reset or when its address is not in that set.
- R5: `size_i` encodes 00 byte, 01 halfword, 10 word, 11 reserved. A halfword with `addr_i[0]`=1, a word with `addr_i[1:0]`≠0, or size 11, completes with `abort_o`=1, `lane_o`=0, `rdata_o`=0 and no write.
- R6: On a completing aligned access, `lane_o` bit k marks byte lane k (bits 8k+7:8k). A byte sets only lane `addr_i[1:0]`. A halfword sets lanes 0-1 or 2-3 by `addr_i[1]`. A word sets all four. A write stores `wdata_i[7:0]` for a byte, `wdata_i[15:0]` for a halfword or the full word, at those lanes only.
- R7: A completing aligned read returns the addressed byte copied into all four lanes, the addressed halfword copied into both halves, or the whole word. `rdata_o` is 0 in every other cycle.
- R8: A non-sequential write with `lock_i`=1, to the same address as the last completed access, where that access was a read made with `lock_i`=1, completes with `wait_o`=0. Without the lock on both phases it takes the setup cycle.
- R9: The RAM index is `addr_i` bits [log2(DEPTH_WORDS)+1:2]. Higher address bits alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mreq_ni | input | 1 | Active-low memory request |
| seq_i | input | 1 | Sequential cycle flag |
| addr_i | input | 32 | Byte address |
| size_i | input | 2 | Transfer size |
| write_i | input | 1 | 1 write, 0 read |
| lock_i | input | 1 | Locked (swap) transfer |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, replicated for narrow sizes |
| wait_o | output | 1 | Stretch the processor clock |
| abort_o | output | 1 | Misaligned or reserved-size access rejected |
| lane_o | output | 4 | Byte lanes of the completing access |

## Verification
The bench builds the controller with DEPTH_WORDS set to 16. A 64-byte model then covers the whole RAM, so every location is preloaded before it is read. Writes at 0x40 and above reach the aliasing of R9. With the small depth, the set of addresses a sequential cycle may use to stay fast, and the addresses just outside that set, are both easy to reach.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  typedef enum logic [1:0] {
    CYC_NSEQ  = 2'b00,
    CYC_SEQ   = 2'b01,
    CYC_IDLE  = 2'b10,
    CYC_COPRO = 2'b11
  } cyc_e;

  function automatic cyc_e classify(input logic mreq_n, input logic seq);
    return cyc_e'({mreq_n, seq});
  endfunction

  // narrow data copied across the bus, lane chosen by offset
  function automatic logic [31:0] spread(input logic [31:0] d, input logic [1:0] sz,
                                         input logic [1:0] off);
    logic [31:0] r;
    case (sz)
      SZ_BYTE: r = {4{d[8*off +: 8]}};
      SZ_HALF: r = {2{d[16*off[1] +: 16]}};
      default: r = d;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mcc_decode.sv
module mcc_decode import mcc_pkg::*; #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mreq_ni,
  input  logic          seq_i,
  input  logic [AW-1:0] addr_i,
  input  logic          write_i,
  input  logic          lock_i,
  output logic          wait_o,
  output logic          done_o
);
  cyc_e          cyc;
  logic          req;
  logic          seq_hit;
  logic          lock_hit;
  logic          fast;
  logic [AW-1:0] last_q;
  logic          valid_q;
  logic          setup_q;
  logic          lkrd_q;

  assign cyc      = classify(mreq_ni, seq_i);
  assign req      = (cyc == CYC_NSEQ) || (cyc == CYC_SEQ);
  assign seq_hit  = (cyc == CYC_SEQ) && valid_q &&
                    (addr_i == last_q || addr_i == last_q + AW'(2) || addr_i == last_q + AW'(4));
  assign lock_hit = (cyc == CYC_NSEQ) && valid_q && lkrd_q && lock_i && write_i &&
                    (addr_i == last_q);
  assign fast     = seq_hit || lock_hit;
  assign wait_o   = req && !fast && !setup_q;
  assign done_o   = req && !wait_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q  <= '0;
      valid_q <= 1'b0;
      setup_q <= 1'b0;
      lkrd_q  <= 1'b0;
    end else begin
      setup_q <= wait_o;
      if (done_o) begin
        last_q  <= addr_i;
        valid_q <= 1'b1;
        lkrd_q  <= lock_i && !write_i;
      end
    end
  end

  p_idle_nowait_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreq_ni |-> !wait_o);
  p_wait_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |=> !wait_o);
  p_seq_word_fast_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mreq_ni && seq_i && valid_q && addr_i == last_q + AW'(4)) |-> !wait_o);
  p_cold_seq_slow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mreq_ni && seq_i && !valid_q && !setup_q) |-> wait_o);
endmodule

// File: rtl/mcc_lanes.sv
module mcc_lanes import mcc_pkg::*; (
  input  logic [1:0] off_i,
  input  logic [1:0] size_i,
  output logic [3:0] be_o,
  output logic       mis_o
);
  always_comb begin
    be_o  = 4'b0000;
    mis_o = 1'b0;
    case (size_i)
      SZ_BYTE: be_o = 4'b0001 << off_i;
      SZ_HALF: begin
        be_o  = off_i[1] ? 4'b1100 : 4'b0011;
        mis_o = off_i[0];
      end
      SZ_WORD: begin
        be_o  = 4'b1111;
        mis_o = (off_i != 2'b00);
      end
      default: mis_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/mcc_ram.sv
module mcc_ram #(
  parameter int DEPTH = 64,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic [3:0]    we_i,
  input  logic [IW-1:0] idx_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o
);
  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [7:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i[k]) mem[idx_i] <= wdata_i[8*k +: 8];
    end
    assign rdata_o[8*k +: 8] = mem[idx_i];
  end
endmodule

// File: rtl/mem_cycle_ctrl.sv
module mem_cycle_ctrl import mcc_pkg::*; #(
  parameter int DEPTH_WORDS = 64,
  localparam int IW         = $clog2(DEPTH_WORDS)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        mreq_ni,
  input  logic        seq_i,
  input  logic [31:0] addr_i,
  input  logic [1:0]  size_i,
  input  logic        write_i,
  input  logic        lock_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        wait_o,
  output logic        abort_o,
  output logic [3:0]  lane_o
);
  logic        done;
  logic [3:0]  be;
  logic        mis;
  logic        ok;
  logic [31:0] ram_rd;

  mcc_decode #(.AW(32)) i_decode (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mreq_ni (mreq_ni),
    .seq_i   (seq_i),
    .addr_i  (addr_i),
    .write_i (write_i),
    .lock_i  (lock_i),
    .wait_o  (wait_o),
    .done_o  (done)
  );

  mcc_lanes i_lanes (
    .off_i  (addr_i[1:0]),
    .size_i (size_i),
    .be_o   (be),
    .mis_o  (mis)
  );

  assign ok = done && !mis;

  mcc_ram #(.DEPTH(DEPTH_WORDS)) i_ram (
    .clk_i   (clk_i),
    .we_i    ((ok && write_i) ? be : 4'b0000),
    .idx_i   (addr_i[IW+1:2]),
    .wdata_i (spread(wdata_i, size_i, 2'b00)),
    .rdata_o (ram_rd)
  );

  assign abort_o = done && mis;
  assign lane_o  = ok ? be : 4'b0000;
  assign rdata_o = (ok && !write_i) ? spread(ram_rd, size_i, addr_i[1:0]) : 32'd0;

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mreq_ni |-> (lane_o == 4'b0000 && !abort_o));
  p_wait_nolane_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |-> (lane_o == 4'b0000 && rdata_o == 32'd0));
  p_abort_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> (lane_o == 4'b0000 && rdata_o == 32'd0));
  p_byte_lane_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mreq_ni && !wait_o && size_i == SZ_BYTE) |-> $countones(lane_o) == 1);
endmodule

// File: tb/test_mem_cycle_ctrl.sv
module test_mem_cycle_ctrl;
  localparam int CLK_P = 10;
  localparam int DEPTH = 16;
  localparam int NB    = DEPTH * 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mreq_n = 1'b1, seq = 1'b0, wr = 1'b0, lk = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [1:0]  size = 2'b10;
  logic [31:0] rdata;
  logic        wt, abrt;
  logic [3:0]  lane;

  always #(CLK_P/2) clk = ~clk;

  mem_cycle_ctrl #(.DEPTH_WORDS(DEPTH)) i_mem_cycle_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .mreq_ni(mreq_n), .seq_i(seq), .addr_i(addr),
    .size_i(size), .write_i(wr), .lock_i(lk), .wdata_i(wdata),
    .rdata_o(rdata), .wait_o(wt), .abort_o(abrt), .lane_o(lane)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference model state
  byte unsigned m [NB];
  logic [31:0]  m_last;
  bit           m_valid, m_setup, m_lkrd;
  bit           x_wait;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(bit mq, bit sq, logic [31:0] a, logic [1:0] sz, bit w, bit l,
                     logic [31:0] wd, string tag);
    bit req, mis, fast, cmp;
    logic [3:0] be;
    logic [31:0] x_rd;
    int b;
    @(negedge clk);
    mreq_n = mq; seq = sq; addr = a; size = sz; wr = w; lk = l; wdata = wd;
    req  = !mq;
    mis  = (sz == 2'b01 && a[0]) || (sz == 2'b10 && a[1:0] != 0) || sz == 2'b11;
    be   = (sz == 2'b00) ? (4'b0001 << a[1:0]) : (sz == 2'b01) ? (a[1] ? 4'b1100 : 4'b0011) : 4'b1111;
    fast = (req && sq && m_valid && (a == m_last || a == m_last + 2 || a == m_last + 4)) ||
           (req && !sq && m_valid && m_lkrd && l && w && a == m_last);
    x_wait = req && !fast && !m_setup;
    cmp  = req && !x_wait;
    b    = int'(a % NB);
    x_rd = 32'd0;
    if (cmp && !mis && !w) begin
      if (sz == 2'b00) x_rd = {4{m[b]}};
      else if (sz == 2'b01) begin b = b & ~1; x_rd = {2{m[b+1], m[b]}}; end
      else begin b = b & ~3; x_rd = {m[b+3], m[b+2], m[b+1], m[b]}; end
    end
    #(CLK_P/2 - 1);
    chk(tag, "wait_o", 32'(wt), 32'(x_wait));
    chk(tag, "abort_o", 32'(abrt), 32'(cmp && mis));
    chk(tag, "lane_o", 32'(lane), (cmp && !mis) ? 32'(be) : 32'd0);
    chk(tag, "rdata_o", rdata, x_rd);
    @(posedge clk);
    m_setup = x_wait;
    if (cmp) begin
      m_last = a; m_valid = 1; m_lkrd = l && !w;
      if (w && !mis) begin
        b = int'(a % NB);
        if (sz == 2'b00) m[b] = wd[7:0];
        else if (sz == 2'b01) begin b = b & ~1; m[b] = wd[7:0]; m[b+1] = wd[15:8]; end
        else begin b = b & ~3; for (int k = 0; k < 4; k++) m[b+k] = wd[8*k +: 8]; end
      end
    end
  endtask

  // hold the request until it completes
  task automatic acc(bit sq, logic [31:0] a, logic [1:0] sz, bit w, bit l,
                     logic [31:0] wd, string tag);
    cyc(1'b0, sq, a, sz, w, l, wd, tag);
    if (x_wait) cyc(1'b0, sq, a, sz, w, l, wd, tag);
  endtask

  task automatic idle(bit sq, string tag);
    cyc(1'b1, sq, 32'h3c, 2'b10, 1'b1, 1'b0, 32'hdead_beef, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    m_last = '0; m_valid = 0; m_setup = 0; m_lkrd = 0;
    for (int i = 0; i < NB; i++) m[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // reset state
    idle(1'b0, "R1");
    // R4: sequential with no history takes a setup cycle; drop it (R2: nothing written)
    cyc(1'b0, 1'b1, 32'h0, 2'b10, 1'b1, 1'b0, 32'h1111_1111, "R4");
    idle(1'b0, "R2");
    // preload every word: non-sequential writes, one wait each (R2)
    for (int i = 0; i < DEPTH; i++)
      acc(1'b0, 32'(i*4), 2'b10, 1'b1, 1'b0, 32'h1000_0000 + 32'(i*32'h0101_0101), "R2");
    // R3: sequential word reads streaming
    acc(1'b0, 32'h0, 2'b10, 1'b0, 1'b0, 0, "R2");
    for (int i = 1; i < 6; i++) cyc(1'b0, 1'b1, 32'(i*4), 2'b10, 1'b0, 1'b0, 0, "R3");
    // R3: same address and +2 halfword steps
    cyc(1'b0, 1'b1, 32'h14, 2'b01, 1'b0, 1'b0, 0, "R3");
    cyc(1'b0, 1'b1, 32'h16, 2'b01, 1'b0, 1'b0, 0, "R3");
    // R1: internal and coprocessor cycles in between do not break the stream or write
    idle(1'b0, "R1");
    idle(1'b1, "R1");
    cyc(1'b0, 1'b1, 32'h18, 2'b10, 1'b0, 1'b0, 0, "R3");
    acc(1'b0, 32'h3c, 2'b10, 1'b0, 1'b0, 0, "R1");
    // R4: sequential out of range
    acc(1'b1, 32'h30, 2'b10, 1'b0, 1'b0, 0, "R4");
    acc(1'b1, 32'h20, 2'b10, 1'b0, 1'b0, 0, "R4");
    // R6: byte writes on every lane, halfword writes, then read back (R7)
    for (int k = 0; k < 4; k++) acc(1'b0, 32'h8 + 32'(k), 2'b00, 1'b1, 1'b0, 32'hffff_ff00 + 32'(k*17), "R6");
    acc(1'b0, 32'hc, 2'b01, 1'b1, 1'b0, 32'h5555_a1b2, "R6");
    acc(1'b0, 32'h12, 2'b01, 1'b1, 1'b0, 32'h6666_c3d4, "R6");
    for (int k = 0; k < 4; k++) acc(1'b0, 32'h8 + 32'(k), 2'b00, 1'b0, 1'b0, 0, "R7");
    acc(1'b0, 32'hc, 2'b01, 1'b0, 1'b0, 0, "R7");
    acc(1'b0, 32'he, 2'b01, 1'b0, 1'b0, 0, "R7");
    acc(1'b0, 32'h10, 2'b10, 1'b0, 1'b0, 0, "R7");
    // R5: misaligned and reserved sizes abort and leave memory intact
    acc(1'b0, 32'h25, 2'b01, 1'b1, 1'b0, 32'h0bad_0bad, "R5");
    acc(1'b0, 32'h26, 2'b10, 1'b1, 1'b0, 32'h0bad_0bad, "R5");
    acc(1'b0, 32'h24, 2'b11, 1'b1, 1'b0, 32'h0bad_0bad, "R5");
    acc(1'b0, 32'h23, 2'b01, 1'b0, 1'b0, 0, "R5");
    acc(1'b0, 32'h24, 2'b10, 1'b0, 1'b0, 0, "R5");
    // R8: locked swap, write phase without setup
    acc(1'b0, 32'h28, 2'b10, 1'b0, 1'b1, 0, "R8");
    idle(1'b0, "R8");
    cyc(1'b0, 1'b0, 32'h28, 2'b10, 1'b1, 1'b1, 32'hcafe_f00d, "R8");
    acc(1'b0, 32'h28, 2'b10, 1'b0, 1'b0, 0, "R8");
    // R8: read without lock -> write phase waits
    acc(1'b0, 32'h2c, 2'b10, 1'b0, 1'b0, 0, "R8");
    acc(1'b0, 32'h2c, 2'b10, 1'b1, 1'b1, 32'h7777_8888, "R8");
    acc(1'b0, 32'h2c, 2'b10, 1'b0, 1'b0, 0, "R8");
    // R9: aliasing above the RAM depth
    acc(1'b0, 32'h44, 2'b10, 1'b1, 1'b0, 32'h9999_0044, "R9");
    acc(1'b0, 32'h4, 2'b10, 1'b0, 1'b0, 0, "R9");
    acc(1'b0, 32'h1000_0004, 2'b00, 1'b0, 1'b0, 0, "R9");
    idle(1'b1, "R1");
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule